// File: doc/BRIEF.md
# Two-Colour Cluster Annealing Sequencer

This block sequences the annealing run of a clustered spin array. Clusters sit in a chain, and only neighbouring clusters share coupling terms. Two clusters that are not adjacent can therefore be updated in the same step. The sequencer splits the clusters into two colours by the parity of their index. It launches every cluster of one colour at once, waits until all of them have finished their swap evaluation, and then launches the other colour. One pair of colour phases forms one update iteration.

Each level runs a fixed number of iterations, and the run covers several levels in sequence. At the start of every reload window the sequencer asks an outside agent to reload the coupling weights. It then asks for a noise-injection step at the current temperature index. The temperature index starts at its hottest value at the start of every level and drops by one for each window that follows. After the last phase of the last level, the sequencer pulses `done_o` and returns to idle. Spin readback is allowed only while the sequencer is idle.

Top module: `cluster_anneal_seq`

## Requirements
- R1: After reset, the block is idle. All requests and cluster starts are low, `done_o` is low, `phase_o` is 0, `readback_en_o` is 1 and `iter_o` is 0.
- R2: A `start_i` pulse seen while idle begins a run at level 0, iteration 0 and the hottest temperature index (N_TEMPS-1, where N_TEMPS = ITERS_PER_LEVEL / RELOAD_EVERY). The first action of the run is a reload request.
- R3: `reload_req_o` stays high until `reload_ack_i` is sampled high. The noise request is raised only after that acknowledge and stays high until `noise_ack_i` is sampled high. The two requests are never high together, and `temp_o` is stable while the noise request waits.
- R4: Each iteration launches phase 0 first, then phase 1. Phase 0 covers the clusters with even index (counting from 0) and phase 1 covers those with odd index. `clu_start_o` pulses for exactly one cycle with the mask of the active phase, and `phase_o` shows the phase.
- R5: The next launch happens only after every cluster of the active phase has pulsed `clu_done_i` at least once since its start. The clusters may finish in different cycles. Done pulses from clusters outside the active phase have no effect.
- R6: A reload and noise pair is requested before iterations 0, RELOAD_EVERY, 2·RELOAD_EVERY and so on of each level. `temp_o` drops by one at each new window inside a level.
- R7: Each level runs ITERS_PER_LEVEL iterations. During an iteration, `iter_o` shows its 0-based index and `level_o` shows the level.
- R8: The run covers N_LEVELS levels. At each new level, `iter_o` returns to 0 and `temp_o` returns to the hottest index.
- R9: `done_o` pulses high for exactly one cycle after the last phase of the last level. The block is idle on the following cycle.
- R10: `readback_en_o` is high only while the block is idle.
- R11: `start_i` has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run start, sampled while idle |
| done_o | output | 1 | One-cycle pulse at the end of the run |
| readback_en_o | output | 1 | Spin readback allowed (idle) |
| phase_o | output | 1 | 0 = even-index clusters, 1 = odd-index clusters |
| clu_start_o | output | N_CLUSTERS | Per-cluster evaluator launch pulse |
| clu_done_i | input | N_CLUSTERS | Per-cluster evaluator finished pulse |
| reload_req_o | output | 1 | Weight reload request |
| reload_ack_i | input | 1 | Weight reload acknowledge |
| noise_req_o | output | 1 | Noise-injection request |
| noise_ack_i | input | 1 | Noise-injection acknowledge |
| temp_o | output | TEMP_W | Temperature index for the noise step, highest = hottest |
| iter_o | output | ITER_W | Iteration index within the level |
| level_o | output | LVL_W | Current hierarchy level |

## Verification
Each cluster in the bench takes a different latency, so a phase that advances on the first done rather than the last one shows up as a launch while some clusters are still busy. Clusters outside the active phase send extra done pulses while the real ones are still working; a design that does not mask these advances early. The acknowledge latencies vary between 1 and 3 cycles, which exposes any request that drops too soon or any noise request that starts before the reload has finished. A start pulse in the middle of a run, followed by a second full run, checks that a busy block ignores start and that a new run comes back at the hottest temperature and level 0.

// File: rtl/ca_sched_pkg.sv
package ca_sched_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RELOAD,
    S_NOISE,
    S_LAUNCH,
    S_WAIT,
    S_FIN
  } seq_state_t;

  function automatic int unsigned safe_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ca_phase_mask.sv
module ca_phase_mask #(
  parameter int unsigned N_CLUSTERS = 32
) (
  input  logic                  phase_i,
  output logic [N_CLUSTERS-1:0] mask_o
);
  for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_bit
    if (c % 2 == 0) begin : g_even
      assign mask_o[c] = ~phase_i;
    end else begin : g_odd
      assign mask_o[c] = phase_i;
    end
  end
endmodule

// File: rtl/ca_done_tracker.sv
module ca_done_tracker #(
  parameter int unsigned N_CLUSTERS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  track_i,
  input  logic [N_CLUSTERS-1:0] active_i,
  input  logic [N_CLUSTERS-1:0] done_i,
  output logic                  all_done_o
);
  logic [N_CLUSTERS-1:0] seen_q;
  logic [N_CLUSTERS-1:0] seen_now;

  assign seen_now   = seen_q | (done_i & active_i);
  assign all_done_o = &(seen_now | ~active_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (clear_i) begin
      seen_q <= '0;
    end else if (track_i) begin
      seen_q <= seen_now;
    end
  end
endmodule

// File: rtl/ca_sched_counters.sv
module ca_sched_counters #(
  parameter int unsigned ITERS_PER_LEVEL = 800,
  parameter int unsigned RELOAD_EVERY    = 200,
  parameter int unsigned N_LEVELS        = 3,
  localparam int unsigned N_TEMPS = (ITERS_PER_LEVEL + RELOAD_EVERY - 1) / RELOAD_EVERY,
  localparam int unsigned ITER_W  = ca_sched_pkg::safe_w(ITERS_PER_LEVEL),
  localparam int unsigned RCNT_W  = ca_sched_pkg::safe_w(RELOAD_EVERY),
  localparam int unsigned TEMP_W  = ca_sched_pkg::safe_w(N_TEMPS),
  localparam int unsigned LVL_W   = ca_sched_pkg::safe_w(N_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ITER_W-1:0] iter_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              last_iter_o,
  output logic              last_level_o,
  output logic              win_end_o
);
  localparam logic [TEMP_W-1:0] TEMP_HOT = TEMP_W'(N_TEMPS - 1);

  logic [ITER_W-1:0] iter_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic [TEMP_W-1:0] temp_q;
  logic [LVL_W-1:0]  level_q;

  assign last_iter_o  = (iter_q == ITER_W'(ITERS_PER_LEVEL - 1));
  assign last_level_o = (level_q == LVL_W'(N_LEVELS - 1));
  assign win_end_o    = (rcnt_q == RCNT_W'(RELOAD_EVERY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q  <= '0;
      rcnt_q  <= '0;
      temp_q  <= TEMP_HOT;
      level_q <= '0;
    end else if (clear_i) begin
      iter_q  <= '0;
      rcnt_q  <= '0;
      temp_q  <= TEMP_HOT;
      level_q <= '0;
    end else if (step_i) begin
      if (last_iter_o) begin
        if (!last_level_o) begin
          iter_q  <= '0;
          rcnt_q  <= '0;
          temp_q  <= TEMP_HOT;
          level_q <= level_q + 1'b1;
        end
      end else begin
        iter_q <= iter_q + 1'b1;
        if (win_end_o) begin
          rcnt_q <= '0;
          if (temp_q != '0) temp_q <= temp_q - 1'b1;
        end else begin
          rcnt_q <= rcnt_q + 1'b1;
        end
      end
    end
  end

  assign iter_o  = iter_q;
  assign temp_o  = temp_q;
  assign level_o = level_q;
endmodule

// File: rtl/cluster_anneal_seq.sv
module cluster_anneal_seq #(
  parameter int unsigned N_CLUSTERS      = 32,
  parameter int unsigned ITERS_PER_LEVEL = 800,
  parameter int unsigned RELOAD_EVERY    = 200,
  parameter int unsigned N_LEVELS        = 3,
  localparam int unsigned N_TEMPS = (ITERS_PER_LEVEL + RELOAD_EVERY - 1) / RELOAD_EVERY,
  localparam int unsigned ITER_W  = ca_sched_pkg::safe_w(ITERS_PER_LEVEL),
  localparam int unsigned TEMP_W  = ca_sched_pkg::safe_w(N_TEMPS),
  localparam int unsigned LVL_W   = ca_sched_pkg::safe_w(N_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic                  done_o,
  output logic                  readback_en_o,
  output logic                  phase_o,
  output logic [N_CLUSTERS-1:0] clu_start_o,
  input  logic [N_CLUSTERS-1:0] clu_done_i,
  output logic                  reload_req_o,
  input  logic                  reload_ack_i,
  output logic                  noise_req_o,
  input  logic                  noise_ack_i,
  output logic [TEMP_W-1:0]     temp_o,
  output logic [ITER_W-1:0]     iter_o,
  output logic [LVL_W-1:0]      level_o
);
  import ca_sched_pkg::*;

  seq_state_t state_q, state_d;
  logic phase_q, phase_d;
  logic [N_CLUSTERS-1:0] active_mask;
  logic all_done, step, clear_run;
  logic last_iter, last_level, win_end;

  ca_phase_mask #(.N_CLUSTERS(N_CLUSTERS)) u_mask (
    .phase_i (phase_q),
    .mask_o  (active_mask)
  );

  ca_done_tracker #(.N_CLUSTERS(N_CLUSTERS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (state_q == S_LAUNCH),
    .track_i    (state_q == S_WAIT),
    .active_i   (active_mask),
    .done_i     (clu_done_i),
    .all_done_o (all_done)
  );

  ca_sched_counters #(
    .ITERS_PER_LEVEL (ITERS_PER_LEVEL),
    .RELOAD_EVERY    (RELOAD_EVERY),
    .N_LEVELS        (N_LEVELS)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_run),
    .step_i       (step),
    .iter_o       (iter_o),
    .temp_o       (temp_o),
    .level_o      (level_o),
    .last_iter_o  (last_iter),
    .last_level_o (last_level),
    .win_end_o    (win_end)
  );

  assign clear_run = (state_q == S_IDLE) && start_i;
  assign step      = (state_q == S_WAIT) && all_done && phase_q;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    unique case (state_q)
      S_IDLE: begin
        phase_d = 1'b0;
        if (start_i) state_d = S_RELOAD;
      end
      S_RELOAD: if (reload_ack_i) state_d = S_NOISE;
      S_NOISE:  if (noise_ack_i)  state_d = S_LAUNCH;
      S_LAUNCH: state_d = S_WAIT;
      S_WAIT: begin
        if (all_done) begin
          if (!phase_q) begin
            phase_d = 1'b1;
            state_d = S_LAUNCH;
          end else begin
            phase_d = 1'b0;
            if (last_iter && last_level) state_d = S_FIN;
            else if (last_iter || win_end) state_d = S_RELOAD;
            else state_d = S_LAUNCH;
          end
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign done_o        = (state_q == S_FIN);
  assign readback_en_o = (state_q == S_IDLE);
  assign phase_o       = phase_q;
  assign reload_req_o  = (state_q == S_RELOAD);
  assign noise_req_o   = (state_q == S_NOISE);
  assign clu_start_o   = (state_q == S_LAUNCH) ? active_mask : '0;
endmodule

// File: rtl/ca_sched_chk.sv
module ca_sched_chk #(
  parameter int unsigned N_CLUSTERS = 32,
  parameter int unsigned TEMP_W     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  done_o,
  input logic                  readback_en_o,
  input logic                  phase_o,
  input logic [N_CLUSTERS-1:0] clu_start_o,
  input logic                  reload_req_o,
  input logic                  reload_ack_i,
  input logic                  noise_req_o,
  input logic                  noise_ack_i,
  input logic [TEMP_W-1:0]     temp_o
);
  function automatic logic [N_CLUSTERS-1:0] even_bits();
    logic [N_CLUSTERS-1:0] m;
    for (int c = 0; c < N_CLUSTERS; c++) m[c] = (c % 2 == 0);
    return m;
  endfunction
  localparam logic [N_CLUSTERS-1:0] EVEN_SET = even_bits();

  p_reload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req_o && !reload_ack_i |=> reload_req_o);
  p_noise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    noise_req_o && !noise_ack_i |=> noise_req_o);
  p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reload_req_o && noise_req_o));
  p_temp_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    noise_req_o && !noise_ack_i |=> $stable(temp_o));
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clu_start_o) |=> (clu_start_o == '0));
  p_start_colour_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clu_start_o) |-> ((clu_start_o & (phase_o ? EVEN_SET : ~EVEN_SET)) == '0));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && readback_en_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    readback_en_o |-> !reload_req_o && !noise_req_o && (clu_start_o == '0));
  p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    readback_en_o && !start_i |=> readback_en_o);
endmodule

bind cluster_anneal_seq ca_sched_chk #(
  .N_CLUSTERS (N_CLUSTERS),
  .TEMP_W     (TEMP_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .done_o        (done_o),
  .readback_en_o (readback_en_o),
  .phase_o       (phase_o),
  .clu_start_o   (clu_start_o),
  .reload_req_o  (reload_req_o),
  .reload_ack_i  (reload_ack_i),
  .noise_req_o   (noise_req_o),
  .noise_ack_i   (noise_ack_i),
  .temp_o        (temp_o)
);

// File: tb/cluster_anneal_seq_tb.sv
module cluster_anneal_seq_tb;
  localparam int NC = 8;
  localparam int IT = 6;
  localparam int RE = 2;
  localparam int LV = 3;
  localparam int NT = IT / RE;
  localparam int IW = 3;
  localparam int TW = 2;
  localparam int LW = 2;
  localparam int K_RELOAD = 0, K_NOISE = 1, K_LAUNCH = 2, K_DONE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, readback_en_o, phase_o;
  logic [NC-1:0] clu_start_o;
  logic [NC-1:0] clu_done_i = '0;
  logic reload_req_o, noise_req_o;
  logic reload_ack_i = 1'b0, noise_ack_i = 1'b0;
  logic [TW-1:0] temp_o;
  logic [IW-1:0] iter_o;
  logic [LW-1:0] level_o;

  always #10 clk = ~clk;

  cluster_anneal_seq #(
    .N_CLUSTERS(NC), .ITERS_PER_LEVEL(IT), .RELOAD_EVERY(RE), .N_LEVELS(LV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .readback_en_o(readback_en_o), .phase_o(phase_o),
    .clu_start_o(clu_start_o), .clu_done_i(clu_done_i),
    .reload_req_o(reload_req_o), .reload_ack_i(reload_ack_i),
    .noise_req_o(noise_req_o), .noise_ack_i(noise_ack_i),
    .temp_o(temp_o), .iter_o(iter_o), .level_o(level_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  logic busy = 1'b0;
  logic saw_done = 1'b0;
  logic prev_done = 1'b0;
  logic [NC-1:0] outstanding = '0;
  int ack_seed = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int kind, input int lvl, input int it,
                                     input int tmp, input int ph, input int mask);
    return {8'(kind), 8'(lvl), 16'(it), 8'(tmp), 8'(ph), 16'(mask)};
  endfunction

  function automatic int colour_mask(input int ph);
    int m = 0;
    for (int c = 0; c < NC; c++) if ((c % 2) == ph) m |= (1 << c);
    return m;
  endfunction

  // Driver side: expected event order from R2, R4, R6, R7, R8, R9
  task automatic push_expected();
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < IT; i++) begin
        if (i % RE == 0) begin
          exp_q.push_back(mk(K_RELOAD, l, i, NT - 1 - i / RE, 0, 0));
          exp_q.push_back(mk(K_NOISE, l, i, NT - 1 - i / RE, 0, 0));
        end
        exp_q.push_back(mk(K_LAUNCH, l, i, NT - 1 - i / RE, 0, colour_mask(0)));
        exp_q.push_back(mk(K_LAUNCH, l, i, NT - 1 - i / RE, 1, colour_mask(1)));
      end
    end
    exp_q.push_back(mk(K_DONE, 0, 0, 0, 0, 0));
  endtask

  task automatic compare_obs(input logic [63:0] obs, input string req);
    logic [63:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req, obs, 64'h0);
    end else begin
      e = exp_q.pop_front();
      chk(obs == e, req, obs, e);
    end
  endtask

  // Monitor / scoreboard, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reload_req_o && reload_ack_i)
        compare_obs(mk(K_RELOAD, int'(level_o), int'(iter_o), int'(temp_o), int'(phase_o), 0), "R6/R8 reload");
      if (noise_req_o && noise_ack_i)
        compare_obs(mk(K_NOISE, int'(level_o), int'(iter_o), int'(temp_o), int'(phase_o), 0), "R3/R6 noise");
      if (reload_req_o && noise_req_o) chk(1'b0, "R3 overlap", 64'h1, 64'h0);
      if (|clu_done_i) outstanding = outstanding & ~clu_done_i;
      if (|clu_start_o) begin
        chk(outstanding == '0, "R5 launch before all active done", 64'(outstanding), 64'h0);
        outstanding = clu_start_o;
        compare_obs(mk(K_LAUNCH, int'(level_o), int'(iter_o), int'(temp_o), int'(phase_o), int'(clu_start_o)), "R4/R7 launch");
      end
      if (done_o) begin
        chk(!prev_done, "R9 done width", 64'h2, 64'h1);
        compare_obs(mk(K_DONE, 0, 0, 0, 0, 0), "R9 done");
        saw_done = 1'b1;
      end
      if (busy) chk(readback_en_o == 1'b0, "R10 readback while busy", 64'(readback_en_o), 64'h0);
      prev_done = done_o;
    end
  end

  // Acknowledge agents with varying latency
  always begin
    int cnt = 0;
    forever begin
      @(posedge clk); #2;
      if (reload_req_o && !reload_ack_i) begin
        cnt++;
        if (cnt >= 1 + (ack_seed % 3)) begin reload_ack_i = 1'b1; cnt = 0; ack_seed++; end
      end else reload_ack_i = 1'b0;
    end
  end

  always begin
    int cnt = 0;
    forever begin
      @(posedge clk); #2;
      if (noise_req_o && !noise_ack_i) begin
        cnt++;
        if (cnt >= 1 + ((ack_seed + 1) % 3)) begin noise_ack_i = 1'b1; cnt = 0; ack_seed++; end
      end else noise_ack_i = 1'b0;
    end
  end

  // Cluster evaluator models: staggered latencies, stray dones on idle clusters (R5)
  always begin
    int left[NC];
    int cyc = 0;
    for (int c = 0; c < NC; c++) left[c] = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      for (int c = 0; c < NC; c++) begin
        clu_done_i[c] = 1'b0;
        if (left[c] > 0) begin
          left[c]--;
          if (left[c] == 0) clu_done_i[c] = 1'b1;
        end
      end
      for (int c = 0; c < NC; c++)
        if (clu_start_o[c]) left[c] = 1 + ((c * 3 + cyc) % 5);
      for (int c = 0; c < NC; c++)
        if (left[c] == 0 && ((cyc + c) % 3 == 0)) clu_done_i[c] = 1'b1;
    end
  end

  task automatic run_once(input bit poke_start);
    push_expected();
    saw_done = 1'b0;
    @(posedge clk); #2;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    busy = 1'b1;
    if (poke_start) begin
      repeat (40) @(posedge clk);
      #2 start_i = 1'b1;   // R11: ignored while busy
      @(posedge clk); #2 start_i = 1'b0;
    end
    while (!saw_done) @(posedge clk);
    busy = 1'b0;
    @(negedge clk);
    chk(readback_en_o == 1'b1, "R10 readback after done", 64'(readback_en_o), 64'h1);
    chk(done_o == 1'b0, "R9 idle after pulse", 64'(done_o), 64'h0);
    chk(exp_q.size() == 0, "R11 leftover expected events", 64'(exp_q.size()), 64'h0);
    exp_q.delete();
    outstanding = '0;
  endtask

  initial begin
    bit timeout = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(readback_en_o == 1'b1, "R1 readback", 64'(readback_en_o), 64'h1);
    chk(!reload_req_o && !noise_req_o, "R1 requests", {62'h0, reload_req_o, noise_req_o}, 64'h0);
    chk(clu_start_o == '0, "R1 starts", 64'(clu_start_o), 64'h0);
    chk(!done_o && !phase_o, "R1 done/phase", {62'h0, done_o, phase_o}, 64'h0);
    chk(iter_o == '0, "R1 iter", 64'(iter_o), 64'h0);
    repeat (4) @(negedge clk);
    chk(readback_en_o == 1'b1 && !reload_req_o, "R10 idle without start", 64'(readback_en_o), 64'h1);
    fork
      begin
        run_once(1'b1);   // R2 R11
        repeat (5) @(posedge clk);
        run_once(1'b0);   // R2 R8 second run restarts hot at level 0
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog", 64'h1, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule